// File: doc/BRIEF.md
# Memory Power-State Sequencer

This block is the digital sequencer of a three-rail memory supply: a switching main rail, a reference that tracks it, and a linear termination regulator. It chooses between a normal state (S0), a standby state (S3) and an off state (S5) from two enable pins. An enabled rail is held inactive until the supply that feeds it is good. The main rail and the reference wait for the input supply. The termination rail waits until the main rail reports that it is in regulation.

When the termination rail starts, it runs a soft-start. The current-limit select stays at the low (1.0 A) setting for a fixed number of internal clock cycles, set by the parameter `SS_CYCLES` (default 128), and then moves to the high (2.5 A) setting. An over-temperature flag shuts everything down until a cool-down flag is seen. A fault input latches all rails off until an enable or a supply is cycled. All outputs are registered and reflect the inputs sampled at the previous clock edge. Reset is synchronous and active high, and it returns the block to S5 with everything off.

Top module: `mem_pwr_seq`

## Requirements
- R1: When `bias_ok` is low at a clock edge, the next cycle shows state S5 with `main_on`, `ref_on`, `in_reg` and `ilim_hi` low and `term_mode` OFF. This includes a bias loss while in S0 with both enables high.
- R2: With `bias_ok` and `main_en` high, `main_on` and `ref_on` are high only when `vin_ok` was high at the same edge. The state is S0 or S3 whatever the value of `vin_ok`.
- R3: In S0, `term_mode` stays OFF while `main_reg` is low.
- R4: Once S0 is held with `main_reg` high, `term_mode` shows SOFT with `ilim_hi` low for exactly `SS_CYCLES` cycles. It then shows NORM with `ilim_hi` high.
- R5: With `main_en` high, `term_en` low and no shutdown, the state is S3, `term_mode` is HIZ, and the main rail and the reference stay on.
- R6: With `main_en` low, the state is S5 and all outputs are off, whatever the value of `term_en`.
- R7: A high `hot` forces S5 with all outputs off. The block stays there until `cool` has been seen high with `hot` low. The cycle after that sighting is still S5, and normal sequencing resumes on the one after.
- R8: A high `fault` forces S5 with all outputs off. The latch clears at an edge where `fault` is low and at least one of `main_en`, `bias_ok` or `vin_ok` is low. Normal sequencing resumes after that edge.
- R9: When the block returns from S3 to S0, soft-start begins again from a count of zero and lasts the full `SS_CYCLES` cycles.
- R10: `in_reg` is high exactly when `main_on` is high and `main_reg` was high at the same edge.
- R11: The state code is 2'b00 for S0, 2'b01 for S3 and 2'b10 for S5. The `term_mode` code is 2'b00 for OFF, 2'b01 for HIZ, 2'b10 for SOFT and 2'b11 for NORM. Reset gives S5, OFF and all enables low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous active-high reset |
| bias_ok | input | 1 | Bias supply above its threshold |
| vin_ok | input | 1 | Input supply above its threshold |
| main_en | input | 1 | Main rail enable pin |
| term_en | input | 1 | Termination rail enable pin |
| main_reg | input | 1 | Main rail is in regulation |
| hot | input | 1 | Over-temperature flag |
| cool | input | 1 | Cool-down flag |
| fault | input | 1 | Fault latch request |
| main_on | output | 1 | Main rail active |
| ref_on | output | 1 | Tracking reference active |
| term_mode | output | 2 | Termination mode code |
| ilim_hi | output | 1 | Termination current limit at the high setting |
| in_reg | output | 1 | In-regulation status |
| state | output | 2 | Power-state code |

## Verification
The bench builds the block with the default `SS_CYCLES` of 128. It therefore runs through the real soft-start length and checks the exact cycle where the current limit switches, in two complete soft-starts: the first entry to S0 and a return from S3. The same build covers bias loss inside S0, the shutdown ordering around the cool-down cycle, and the clearing of the fault latch by cycling an enable.

// File: rtl/mps_pkg.sv
package mps_pkg;

    typedef enum logic [1:0] {
        ST_S0 = 2'b00,
        ST_S3 = 2'b01,
        ST_S5 = 2'b10
    } pstate_e;

    typedef enum logic [1:0] {
        TM_OFF  = 2'b00,
        TM_HIZ  = 2'b01,
        TM_SOFT = 2'b10,
        TM_NORM = 2'b11
    } tmode_e;

    typedef struct packed {
        logic main_on;
        logic ref_on;
        logic in_reg;
    } rail_out_t;

    function automatic pstate_e pick_state(input logic bias, input logic men,
                                           input logic ten, input logic kill);
        if (!bias || !men || kill) return ST_S5;
        return ten ? ST_S0 : ST_S3;
    endfunction

endpackage

// File: rtl/mps_guard.sv
module mps_guard (
    input  logic clk,
    input  logic rst,
    input  logic bias_ok,
    input  logic vin_ok,
    input  logic main_en,
    input  logic hot,
    input  logic cool,
    input  logic fault,
    output logic kill
);
    logic therm_q;
    logic flt_q;
    logic cycled;

    assign cycled = !main_en || !bias_ok || !vin_ok;
    assign kill   = hot || fault || therm_q || flt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            therm_q <= 1'b0;
            flt_q   <= 1'b0;
        end else begin
            if (hot)       therm_q <= 1'b1;
            else if (cool) therm_q <= 1'b0;
            if (fault)       flt_q <= 1'b1;
            else if (cycled) flt_q <= 1'b0;
        end
    end

    // R7: thermal hold persists without a cool-down sighting
    a_r7_therm_hold: assert property (@(posedge clk) disable iff (rst)
        (therm_q && !cool && !hot) |=> kill);

endmodule

// File: rtl/mps_state.sv
module mps_state
    import mps_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      bias_ok,
    input  logic      vin_ok,
    input  logic      main_en,
    input  logic      term_en,
    input  logic      main_reg,
    input  logic      kill,
    output pstate_e   nxt,
    output pstate_e   st_q,
    output rail_out_t rails_q
);
    rail_out_t rails_d;

    always_comb begin
        nxt             = pick_state(bias_ok, main_en, term_en, kill);
        rails_d.main_on = (nxt != ST_S5) && vin_ok;
        rails_d.ref_on  = (nxt != ST_S5) && vin_ok;
        rails_d.in_reg  = (nxt != ST_S5) && vin_ok && main_reg;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_S5;
            rails_q <= '0;
        end else begin
            st_q    <= nxt;
            rails_q <= rails_d;
        end
    end

    // R2: main rail never active after an input-supply low sample
    a_r2_vin_gate: assert property (@(posedge clk) disable iff (rst)
        !vin_ok |=> !rails_q.main_on && !rails_q.ref_on);

endmodule

// File: rtl/mps_term.sv
module mps_term
    import mps_pkg::*;
#(
    parameter int SS_CYCLES = 128
) (
    input  logic    clk,
    input  logic    rst,
    input  pstate_e nxt,
    input  logic    main_reg,
    output tmode_e  mode_q,
    output logic    ilim_q
);
    localparam int CW = (SS_CYCLES > 2) ? $clog2(SS_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(SS_CYCLES - 1);

    logic [CW-1:0] cnt_q, cnt_d;
    tmode_e        mode_d;
    logic          ilim_d;

    always_comb begin
        mode_d = mode_q;
        cnt_d  = cnt_q;
        ilim_d = ilim_q;
        if (nxt != ST_S0 || !main_reg) begin
            mode_d = (nxt == ST_S3) ? TM_HIZ : TM_OFF;
            cnt_d  = '0;
            ilim_d = 1'b0;
        end else begin
            unique case (mode_q)
                TM_OFF, TM_HIZ: begin
                    mode_d = TM_SOFT;
                    cnt_d  = '0;
                end
                TM_SOFT: begin
                    if (cnt_q == LAST) begin
                        mode_d = TM_NORM;
                        ilim_d = 1'b1;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                default: mode_d = TM_NORM;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= TM_OFF;
            cnt_q  <= '0;
            ilim_q <= 1'b0;
        end else begin
            mode_q <= mode_d;
            cnt_q  <= cnt_d;
            ilim_q <= ilim_d;
        end
    end

    // R4: high limit only after the full soft-start count
    a_r4_full_soft: assert property (@(posedge clk) disable iff (rst)
        $rose(ilim_q) |-> ($past(mode_q) == TM_SOFT && $past(cnt_q) == LAST));
    // R3: termination stays off without main regulation
    a_r3_wait_main: assert property (@(posedge clk) disable iff (rst)
        !main_reg |=> mode_q != TM_SOFT && mode_q != TM_NORM);
    // R9: normal mode is reached only through soft-start
    a_r9_norm_path: assert property (@(posedge clk) disable iff (rst)
        mode_q == TM_NORM |-> ($past(mode_q) == TM_SOFT || $past(mode_q) == TM_NORM));

endmodule

// File: rtl/mem_pwr_seq.sv
module mem_pwr_seq
    import mps_pkg::*;
#(
    parameter int SS_CYCLES = 128
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bias_ok,
    input  logic       vin_ok,
    input  logic       main_en,
    input  logic       term_en,
    input  logic       main_reg,
    input  logic       hot,
    input  logic       cool,
    input  logic       fault,
    output logic       main_on,
    output logic       ref_on,
    output logic [1:0] term_mode,
    output logic       ilim_hi,
    output logic       in_reg,
    output logic [1:0] state
);
    logic      kill;
    pstate_e   nxt, st_q;
    rail_out_t rails_q;
    tmode_e    mode_q;

    mps_guard u_guard (
        .clk(clk), .rst(rst), .bias_ok(bias_ok), .vin_ok(vin_ok),
        .main_en(main_en), .hot(hot), .cool(cool), .fault(fault), .kill(kill)
    );

    mps_state u_state (
        .clk(clk), .rst(rst), .bias_ok(bias_ok), .vin_ok(vin_ok),
        .main_en(main_en), .term_en(term_en), .main_reg(main_reg),
        .kill(kill), .nxt(nxt), .st_q(st_q), .rails_q(rails_q)
    );

    mps_term #(.SS_CYCLES(SS_CYCLES)) u_term (
        .clk(clk), .rst(rst), .nxt(nxt), .main_reg(main_reg),
        .mode_q(mode_q), .ilim_q(ilim_q_w)
    );

    logic ilim_q_w;

    assign main_on   = rails_q.main_on;
    assign ref_on    = rails_q.ref_on;
    assign in_reg    = rails_q.in_reg;
    assign term_mode = mode_q;
    assign ilim_hi   = ilim_q_w;
    assign state     = st_q;

    // R1: bias loss turns everything off
    a_r1_bias_off: assert property (@(posedge clk) disable iff (rst)
        !bias_ok |=> state == ST_S5 && !main_on && term_mode == TM_OFF);
    // R7: over-temperature forces the off state
    a_r7_hot_off: assert property (@(posedge clk) disable iff (rst)
        hot |=> state == ST_S5 && !main_on && !ref_on);
    // R8: a fault request turns the rails off
    a_r8_fault_off: assert property (@(posedge clk) disable iff (rst)
        fault |=> !main_on && !ref_on && !in_reg);
    // R5: termination inactive while its enable is low
    a_r5_no_term: assert property (@(posedge clk) disable iff (rst)
        !term_en |=> term_mode != TM_SOFT && term_mode != TM_NORM);

endmodule

// File: tb/mem_pwr_seq_test.sv
`timescale 1ns/1ps
module mem_pwr_seq_test;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bias_ok = 0, vin_ok = 0, main_en = 0, term_en = 0;
    logic main_reg = 0, hot = 0, cool = 0, fault = 0;
    logic main_on, ref_on, ilim_hi, in_reg;
    logic [1:0] term_mode, state;

    always #5 clk = ~clk;

    mem_pwr_seq uut (
        .clk(clk), .rst(rst), .bias_ok(bias_ok), .vin_ok(vin_ok),
        .main_en(main_en), .term_en(term_en), .main_reg(main_reg),
        .hot(hot), .cool(cool), .fault(fault),
        .main_on(main_on), .ref_on(ref_on), .term_mode(term_mode),
        .ilim_hi(ilim_hi), .in_reg(in_reg), .state(state)
    );

    localparam int SOFT_LEN = 128;

    int n_chk = 0, n_bad = 0;
    string tag = "R11";
    bit started = 0;
    bit done = 0;

    // behavioural reference
    int e_st = 2, e_mode = 0, soft_age = 0;
    bit e_ilim = 0, e_main = 0, e_inreg = 0;
    bit hot_hold = 0, flt_hold = 0;
    int soft_run = 0;

    always @(posedge clk) begin
        started = 1;
        if (rst) begin
            e_st = 2; e_mode = 0; soft_age = 0; e_ilim = 0;
            e_main = 0; e_inreg = 0; hot_hold = 0; flt_hold = 0;
        end else begin
            bit blocked;
            blocked = hot || fault || hot_hold || flt_hold;
            if (!bias_ok || !main_en || blocked) e_st = 2;
            else e_st = term_en ? 0 : 1;
            if (hot) hot_hold = 1; else if (cool) hot_hold = 0;
            if (fault) flt_hold = 1;
            else if (!main_en || !bias_ok || !vin_ok) flt_hold = 0;
            e_main  = (e_st != 2) && vin_ok;
            e_inreg = e_main && main_reg;
            if (e_st != 0 || !main_reg) begin
                e_mode = (e_st == 1) ? 1 : 0;
                soft_age = 0; e_ilim = 0;
            end else if (e_mode == 0 || e_mode == 1) begin
                e_mode = 2; soft_age = 1;
            end else if (e_mode == 2) begin
                if (soft_age >= SOFT_LEN) begin e_mode = 3; e_ilim = 1; end
                else soft_age++;
            end
        end
    end

    always @(negedge clk) begin
        if (started && !done) begin
            n_chk++;
            if (state !== 2'(e_st) || term_mode !== 2'(e_mode) ||
                main_on !== e_main || ref_on !== e_main ||
                in_reg !== e_inreg || ilim_hi !== e_ilim) begin
                n_bad++;
                $display("FAIL %s t=%0t st=%b/%0d mode=%b/%0d main=%b/%b ref=%b in_reg=%b/%b ilim=%b/%b",
                         tag, $time, state, e_st, term_mode, e_mode, main_on, e_main,
                         ref_on, in_reg, e_inreg, ilim_hi, e_ilim);
            end
            if (term_mode == 2'b10) soft_run++;
        end
    end

    task automatic go(int n);
        repeat (n) @(posedge clk);
        #3;
    endtask

    task automatic check_val(string t, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", t, act, exp);
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        go(3);
        rst = 0;
        tag = "R11"; go(2);
        check_val("R11 reset state code", int'(state), 2);
        // R1: enables high but no bias
        tag = "R1"; main_en = 1; term_en = 1; vin_ok = 1; main_reg = 1; go(5);
        check_val("R1 no bias off", int'(main_on), 0);
        // R2: bias up, input supply not yet good, standby
        tag = "R2"; term_en = 0; main_reg = 0; vin_ok = 0; bias_ok = 1; go(5);
        check_val("R2 held inactive", int'(main_on), 0);
        vin_ok = 1; go(3);
        check_val("R2 activated", int'(main_on), 1);
        // R5 standby with high-impedance termination
        tag = "R5"; go(3);
        check_val("R5 standby code", int'(state), 1);
        // R10 regulation status
        tag = "R10"; main_reg = 1; go(2); main_reg = 0; go(2);
        // R3 termination waits for regulation
        tag = "R3"; term_en = 1; go(10);
        check_val("R3 term off", int'(term_mode), 0);
        // R4 soft-start length
        tag = "R4"; soft_run = 0; main_reg = 1; go(SOFT_LEN + 10);
        check_val("R4 soft cycles", soft_run, SOFT_LEN);
        check_val("R4 high limit", int'(ilim_hi), 1);
        // R5 back to standby
        tag = "R5"; term_en = 0; go(5);
        check_val("R5 hiz", int'(term_mode), 1);
        // R9 partial soft-start then full restart
        tag = "R9"; term_en = 1; go(50); term_en = 0; go(2);
        soft_run = 0; term_en = 1; go(SOFT_LEN + 10);
        check_val("R9 restart soft cycles", soft_run, SOFT_LEN);
        // R6 main enable low, term enable don't care
        tag = "R6"; main_en = 0; go(5); term_en = 0; go(3);
        check_val("R6 off code", int'(state), 2);
        // R8 fault latch
        tag = "R8"; main_en = 1; term_en = 1; go(20);
        fault = 1; go(1); fault = 0; go(10);
        check_val("R8 latched off", int'(main_on), 0);
        main_en = 0; go(2); main_en = 1; go(5);
        check_val("R8 recovered", int'(main_on), 1);
        // R7 thermal shutdown
        tag = "R7"; go(10); hot = 1; go(1); hot = 0; go(10);
        check_val("R7 held off", int'(state), 2);
        cool = 1; go(1); cool = 0; go(5);
        check_val("R7 resumed", int'(state), 0);
        // R1 bias fails in S0 with both enables high
        tag = "R1"; go(5); bias_ok = 0; go(3);
        check_val("R1 bias loss in S0", int'(state), 2);
        bias_ok = 1; go(5);
        finish_run();
    end

endmodule